// File: doc/BRIEF.md
# Digital Potentiometer Command Controller

This block interprets two-wire serial commands that a separate serial slave front end has already framed into bytes. It keeps the wiper settings of three digital potentiometers. The front end gives the block a byte with a one-cycle valid strobe and one-cycle strobes for bus start and stop conditions. The block answers each byte on an acknowledge output. Each potentiometer has two registers. The working wiper register sets the tap. The persistent register supplies the wiper value after a supply loss. A flag bit in the instruction byte chooses, on each write, whether the data goes to the wiper register alone or to both registers.

When the supply-good input rises, the block waits. Once that input has been sampled high on a parameterised number of consecutive clock edges, the block copies each persistent value into its wiper. Any low sample restarts the wait, which filters ringing on hot insertion. A random-address read returns the current wiper value on a separate data strobe. Each wiper drives a one-hot tap-enable field. On every change the new tap switch turns on one cycle before the old one turns off.

Top module: `potctl_top`

## Requirements
- R1: After reset, `busy` and `ack` are low and every potentiometer's tap field selects tap 0. Bytes are refused until `pwr_good` has been sampled high on PU_CYCLES consecutive rising edges. At that edge each wiper loads its persistent value, which is NV_INIT after reset.
- R2: A single low sample of `pwr_good` makes the block refuse commands and restarts the qualification count from zero. After the count completes again, the wipers reload from the persistent registers.
- R3: The first byte after a start is acknowledged only if bits [7:1] equal 1010111 and bit 0 (read/write flag, 0 = write) is 0. Any other first byte is not acknowledged, and every byte up to the next start is ignored.
- R4: Instruction bits [1:0] select potentiometer 0, 1 or 2. The value 3 is not acknowledged, and the rest of that transaction is ignored.
- R5: A data byte after an instruction with bit 7 = 0 updates only the selected wiper register. After a supply cycle that wiper returns to its old persistent value.
- R6: A data byte after an instruction with bit 7 = 1 updates the wiper and persistent registers together, so the value survives a supply cycle.
- R7: The sequence start, 0xAE, instruction, start, 0xAF is a read. In the cycle after the 0xAF byte, `ack` and `rd_valid` are high together, and `rd_data` holds the selected wiper value, zero-extended. Bytes that follow a completed write or read get no acknowledge.
- R8: A persistent write raises `busy` for exactly NV_BUSY_CYCLES cycles, starting the cycle after the data byte. Address bytes arriving while `busy` is high are not acknowledged.
- R9: A stop before the data byte abandons the command. No register changes.
- R10: `ack` is high for exactly one cycle: the cycle after the `rx_valid` of an accepted byte.
- R11: Bit `p*TAPS + w` of `tap_en` is set when potentiometer p holds wiper value w. After a wiper change, both the old and the new bit are set for one cycle. After that, only the new bit is set.
- R12: Data bits at and above WIPER_W (bits 7:6 by default) are discarded. A write of 0xFF stores 63.
- R13: Bytes that arrive after a stop and before a new start are not acknowledged and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply-good indication, asynchronous to commands |
| bus_start | input | 1 | One-cycle strobe: start or repeated start seen |
| bus_stop | input | 1 | One-cycle strobe: stop seen |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte |
| ack | output | 1 | Acknowledge for the byte of the previous cycle |
| rd_valid | output | 1 | Read answer is valid on `rd_data` |
| rd_data | output | 8 | Wiper value returned by a read |
| busy | output | 1 | Persistent write in progress |
| tap_en | output | N_POT*TAPS | One-hot tap enables, one TAPS-wide field per potentiometer |

## Verification
If the wiper register holds a wrong value, the tap field shows it two edges after the data byte. A wrong persistent value stays hidden until a supply cycle and recall, or until a later read. For that reason the bench power-cycles the block after mixed volatile and persistent writes. A decoder in the wrong state shows up on `ack` one cycle after the next byte. A wrong busy count shows up on the single edge where `busy` falls.

// File: rtl/potctl_pkg.sv
// Shared constants and types for the potentiometer command controller.
// Assumes the byte framing (start/stop/byte strobes) is done upstream.
package potctl_pkg;

    // Seven-bit device identifier that a command must carry in bits [7:1].
    localparam logic [6:0] DEV_ID = 7'b1010111;

    // Command decoder states.
    typedef enum logic [2:0] {
        ST_IDLE,   // no transaction open
        ST_ADDR,   // expecting the first address byte
        ST_INSTR,  // expecting the instruction byte
        ST_DATA,   // expecting data, or a repeated start for a read
        ST_RADDR,  // expecting the repeated address byte
        ST_SKIP    // transaction rejected or done; wait for start
    } cmd_st_t;

endpackage

// File: rtl/potctl_cmd.sv
// Command decoder: walks address, instruction and data bytes, decides the
// acknowledge, issues register writes and read answers, and times the busy
// window of a persistent write.
// Assumes: bus_start, bus_stop and rx_valid never coincide; WIPER_W <= 8.
module potctl_cmd
    import potctl_pkg::*;
#(
    parameter int N_POT          = 3,
    parameter int WIPER_W        = 6,
    parameter int NV_BUSY_CYCLES = 40
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_valid,
    input  logic [7:0]                 rx_byte,
    input  logic                       bus_start,
    input  logic                       bus_stop,
    input  logic                       ready,
    input  logic [N_POT*WIPER_W-1:0]   wiper_flat,
    output logic                       wr_en,
    output logic                       wr_nv,
    output logic [1:0]                 wr_idx,
    output logic [WIPER_W-1:0]         wr_data,
    output logic                       ack,
    output logic                       rd_valid,
    output logic [7:0]                 rd_data,
    output logic                       busy
);

    localparam int         BW     = $clog2(NV_BUSY_CYCLES + 1);
    localparam logic [2:0] NPOT_L = 3'(N_POT);

    cmd_st_t            st_q, st_d;
    logic [1:0]         idx_q, idx_d;
    logic               wt_q, wt_d;
    logic [BW-1:0]      bcnt_q;
    logic               accept, rd_fire, addr_ok;
    logic [WIPER_W-1:0] rd_sel;

    assign addr_ok = (rx_byte[7:1] == DEV_ID);
    assign busy    = (bcnt_q != '0);
    assign wr_idx  = idx_q;
    assign wr_data = rx_byte[WIPER_W-1:0];

    // Select the addressed wiper for a read answer.
    always_comb begin
        rd_sel = '0;
        for (int p = 0; p < N_POT; p++) begin
            if (idx_q == 2'(p)) rd_sel = wiper_flat[p*WIPER_W +: WIPER_W];
        end
    end

    // Next-state, acknowledge and write-strobe decision per byte or strobe.
    always_comb begin
        st_d    = st_q;
        idx_d   = idx_q;
        wt_d    = wt_q;
        accept  = 1'b0;
        rd_fire = 1'b0;
        wr_en   = 1'b0;
        wr_nv   = 1'b0;
        if (bus_stop) begin
            st_d = ST_IDLE;
        end else if (bus_start) begin
            st_d = (st_q == ST_DATA) ? ST_RADDR : ST_ADDR;
        end else if (rx_valid) begin
            unique case (st_q)
                ST_ADDR: begin
                    if (ready && !busy && addr_ok && !rx_byte[0]) begin
                        accept = 1'b1;
                        st_d   = ST_INSTR;
                    end else begin
                        st_d = ST_SKIP;
                    end
                end
                ST_INSTR: begin
                    if (ready && ({1'b0, rx_byte[1:0]} < NPOT_L)) begin
                        accept = 1'b1;
                        idx_d  = rx_byte[1:0];
                        wt_d   = rx_byte[7];
                        st_d   = ST_DATA;
                    end else begin
                        st_d = ST_SKIP;
                    end
                end
                ST_DATA: begin
                    if (ready) begin
                        accept = 1'b1;
                        wr_en  = 1'b1;
                        wr_nv  = wt_q;
                    end
                    st_d = ST_SKIP;
                end
                ST_RADDR: begin
                    if (ready && !busy && addr_ok) begin
                        accept = 1'b1;
                        if (rx_byte[0]) begin
                            rd_fire = 1'b1;
                            st_d    = ST_SKIP;
                        end else begin
                            st_d = ST_INSTR;
                        end
                    end else begin
                        st_d = ST_SKIP;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    // Decoder state and latched instruction fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
            wt_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
            wt_q  <= wt_d;
        end
    end

    // Registered acknowledge and read answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack      <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            ack      <= accept;
            rd_valid <= rd_fire;
            rd_data  <= rd_fire ? 8'(rd_sel) : 8'h00;
        end
    end

    // Busy window counter for persistent writes.
    always_ff @(posedge clk) begin
        if (!rst_n)              bcnt_q <= '0;
        else if (wr_en && wr_nv) bcnt_q <= BW'(NV_BUSY_CYCLES);
        else if (bcnt_q != '0)   bcnt_q <= bcnt_q - 1'b1;
    end

endmodule

// File: rtl/potctl_store.sv
// Wiper and persistent registers with supply qualification and recall.
// Assumes writes arrive only while ready is high (the decoder gates them).
module potctl_store #(
    parameter int N_POT     = 3,
    parameter int WIPER_W   = 6,
    parameter int PU_CYCLES = 16,
    parameter int NV_INIT   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pwr_good,
    input  logic                     wr_en,
    input  logic                     wr_nv,
    input  logic [1:0]               wr_idx,
    input  logic [WIPER_W-1:0]       wr_data,
    output logic                     ready,
    output logic [N_POT*WIPER_W-1:0] wiper_flat
);

    localparam int PU_W = (PU_CYCLES > 1) ? $clog2(PU_CYCLES) : 1;

    logic [PU_W-1:0] pu_cnt_q;
    logic            ready_q;
    logic            recall;

    assign recall = pwr_good && !ready_q && (pu_cnt_q == PU_W'(PU_CYCLES - 1));
    assign ready  = ready_q;

    // Supply qualification: consecutive good samples, restart on any drop.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            pu_cnt_q <= '0;
            ready_q  <= 1'b0;
        end else if (!ready_q) begin
            if (recall) ready_q  <= 1'b1;
            else        pu_cnt_q <= pu_cnt_q + 1'b1;
        end
    end

    for (genvar p = 0; p < N_POT; p++) begin : g_pot
        logic [WIPER_W-1:0] wip_q, nv_q;
        logic               hit;

        assign hit = wr_en && (wr_idx == 2'(p));
        assign wiper_flat[p*WIPER_W +: WIPER_W] = wip_q;

        // Working wiper: recalled on qualification, else written by command.
        always_ff @(posedge clk) begin
            if (!rst_n)      wip_q <= '0;
            else if (recall) wip_q <= nv_q;
            else if (hit)    wip_q <= wr_data;
        end

        // Persistent copy: written only by a persistent write.
        always_ff @(posedge clk) begin
            if (!rst_n)             nv_q <= WIPER_W'(NV_INIT);
            else if (hit && wr_nv)  nv_q <= wr_data;
        end
    end

endmodule

// File: rtl/potctl_tapsel.sv
// One-hot tap decoder with a one-cycle make-before-break overlap.
// Assumes the wiper input is a register output (one change per edge at most).
module potctl_tapsel #(
    parameter int WIPER_W = 6,
    parameter int TAPS    = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIPER_W-1:0] wiper,
    output logic [TAPS-1:0]    tap_en
);

    localparam logic [TAPS-1:0] ONE = {{(TAPS-1){1'b0}}, 1'b1};

    logic [WIPER_W-1:0] cur_q, old_q;
    logic               ovl_q;

    // Track the shown tap, the one before it, and whether both must be on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            old_q <= '0;
            ovl_q <= 1'b0;
        end else begin
            cur_q <= wiper;
            old_q <= cur_q;
            ovl_q <= (wiper != cur_q);
        end
    end

    // Decode: new tap always, old tap during the overlap cycle.
    always_comb begin
        tap_en = ONE << cur_q;
        if (ovl_q) tap_en = tap_en | (ONE << old_q);
    end

endmodule

// File: rtl/potctl_top.sv
// Top of the potentiometer command controller: decoder, register store and
// one tap decoder per potentiometer.
// Assumes a byte-framing front end and WIPER_W <= 8, N_POT <= 4.
module potctl_top #(
    parameter int N_POT          = 3,
    parameter int WIPER_W        = 6,
    parameter int PU_CYCLES      = 16,
    parameter int NV_BUSY_CYCLES = 40,
    parameter int NV_INIT        = 5,
    parameter int TAPS           = 1 << WIPER_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_good,
    input  logic                  bus_start,
    input  logic                  bus_stop,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_byte,
    output logic                  ack,
    output logic                  rd_valid,
    output logic [7:0]            rd_data,
    output logic                  busy,
    output logic [N_POT*TAPS-1:0] tap_en
);

    logic                     ready;
    logic                     wr_en, wr_nv;
    logic [1:0]               wr_idx;
    logic [WIPER_W-1:0]       wr_data;
    logic [N_POT*WIPER_W-1:0] wiper_flat;

    potctl_cmd #(
        .N_POT(N_POT), .WIPER_W(WIPER_W), .NV_BUSY_CYCLES(NV_BUSY_CYCLES)
    ) u_cmd (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .bus_start(bus_start), .bus_stop(bus_stop), .ready(ready),
        .wiper_flat(wiper_flat), .wr_en(wr_en), .wr_nv(wr_nv),
        .wr_idx(wr_idx), .wr_data(wr_data), .ack(ack),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy)
    );

    potctl_store #(
        .N_POT(N_POT), .WIPER_W(WIPER_W), .PU_CYCLES(PU_CYCLES), .NV_INIT(NV_INIT)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .wr_en(wr_en),
        .wr_nv(wr_nv), .wr_idx(wr_idx), .wr_data(wr_data), .ready(ready),
        .wiper_flat(wiper_flat)
    );

    for (genvar p = 0; p < N_POT; p++) begin : g_tap
        potctl_tapsel #(.WIPER_W(WIPER_W), .TAPS(TAPS)) u_tap (
            .clk(clk), .rst_n(rst_n),
            .wiper(wiper_flat[p*WIPER_W +: WIPER_W]),
            .tap_en(tap_en[p*TAPS +: TAPS])
        );
    end

endmodule

// File: rtl/potctl_chk.sv
// Port-level assertion checker for potctl_top, attached by bind below.
// Assumes the bound instance's parameters are passed through unchanged.
module potctl_chk #(
    parameter int N_POT          = 3,
    parameter int WIPER_W        = 6,
    parameter int NV_BUSY_CYCLES = 40,
    parameter int TAPS           = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rx_valid,
    input logic                  ack,
    input logic                  rd_valid,
    input logic [7:0]            rd_data,
    input logic                  busy,
    input logic [N_POT*TAPS-1:0] tap_en
);

    int unsigned blen;

    // Length of the current busy window so far.
    always_ff @(posedge clk) begin
        if (!rst_n)    blen <= 0;
        else if (busy) blen <= blen + 1;
        else           blen <= 0;
    end

    p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(blen) == NV_BUSY_CYCLES - 1));

    p_busy_blocks_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !$past(busy));

    p_ack_after_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(rx_valid));

    p_read_acked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ack);

    if (WIPER_W < 8) begin : g_rdw
        p_rd_width_r12: assert property (@(posedge clk) disable iff (!rst_n)
            rd_valid |-> (rd_data[7:WIPER_W] == '0));
    end

    for (genvar p = 0; p < N_POT; p++) begin : g_tp
        p_tap_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(tap_en[p*TAPS +: TAPS]) >= 1) &&
            ($countones(tap_en[p*TAPS +: TAPS]) <= 2));
        p_tap_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(tap_en[p*TAPS +: TAPS]) == 2) |->
            (tap_en[p*TAPS +: TAPS] != $past(tap_en[p*TAPS +: TAPS])));
    end

endmodule

bind potctl_top potctl_chk #(
    .N_POT(N_POT), .WIPER_W(WIPER_W), .NV_BUSY_CYCLES(NV_BUSY_CYCLES), .TAPS(TAPS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .ack(ack),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .tap_en(tap_en)
);

// File: tb/potctl_top_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus directed
// scenario checks with literal expected values.
module potctl_top_tb_top;

    localparam int NP = 3;
    localparam int WW = 6;
    localparam int TP = 64;
    localparam int PU = 16;
    localparam int NB = 40;
    localparam int NI = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_good = 1'b0;
    logic          bus_start = 1'b0;
    logic          bus_stop = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_byte = 8'h00;
    logic          ack, rd_valid, busy;
    logic [7:0]    rd_data;
    logic [NP*TP-1:0] tap_en;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    cmp_on = 1'b0;
    string cur_req = "R1";

    // Last-byte observation, sampled one cycle after the byte.
    logic       l_ack, l_rdv;
    logic [7:0] l_rdd;

    always #10 clk = ~clk;

    potctl_top #(
        .N_POT(NP), .WIPER_W(WW), .PU_CYCLES(PU),
        .NV_BUSY_CYCLES(NB), .NV_INIT(NI)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .bus_start(bus_start),
        .bus_stop(bus_stop), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .ack(ack), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
        .tap_en(tap_en)
    );

    // ---------------- reference model ----------------
    int m_st = 0;      // 0 idle,1 addr,2 instr,3 data,4 raddr,5 skip
    int m_idx = 0, m_wt = 0, m_busy = 0, m_cnt = 0;
    bit m_rdy = 0;
    int wip[NP], nv[NP], h1[NP], h2[NP];
    bit e_ack = 0, e_rdv = 0;
    int e_rdd = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_idx = 0; m_wt = 0; m_busy = 0; m_cnt = 0; m_rdy = 0;
            e_ack = 0; e_rdv = 0; e_rdd = 0;
            for (int p = 0; p < NP; p++) begin
                wip[p] = 0; nv[p] = NI; h1[p] = 0; h2[p] = 0;
            end
        end else begin
            bit nvw;
            bit dev;
            nvw = 0;
            for (int p = 0; p < NP; p++) begin
                h2[p] = h1[p]; h1[p] = wip[p];
            end
            e_ack = 0; e_rdv = 0; e_rdd = 0;
            dev = (rx_byte >> 1) == 8'd87;
            if (bus_stop) m_st = 0;
            else if (bus_start) m_st = (m_st == 3) ? 4 : 1;
            else if (rx_valid) begin
                case (m_st)
                    1: if (m_rdy && m_busy == 0 && dev && !rx_byte[0]) begin
                           e_ack = 1; m_st = 2;
                       end else m_st = 5;
                    2: if (m_rdy && int'(rx_byte[1:0]) < NP) begin
                           e_ack = 1; m_idx = rx_byte[1:0]; m_wt = rx_byte[7]; m_st = 3;
                       end else m_st = 5;
                    3: begin
                           if (m_rdy) begin
                               e_ack = 1;
                               wip[m_idx] = rx_byte % TP;
                               if (m_wt != 0) begin nv[m_idx] = rx_byte % TP; nvw = 1; end
                           end
                           m_st = 5;
                       end
                    4: if (m_rdy && m_busy == 0 && dev) begin
                           e_ack = 1;
                           if (rx_byte[0]) begin e_rdv = 1; e_rdd = wip[m_idx]; m_st = 5; end
                           else m_st = 2;
                       end else m_st = 5;
                    default: ;
                endcase
            end
            if (nvw) m_busy = NB;
            else if (m_busy > 0) m_busy = m_busy - 1;
            if (!pwr_good) begin m_cnt = 0; m_rdy = 0; end
            else if (!m_rdy) begin
                if (m_cnt == PU - 1) begin
                    m_rdy = 1;
                    for (int p = 0; p < NP; p++) wip[p] = nv[p];
                end else m_cnt = m_cnt + 1;
            end
        end
    end

    function automatic logic [NP*TP-1:0] exp_taps();
        logic [NP*TP-1:0] v;
        v = '0;
        for (int p = 0; p < NP; p++) begin
            v[p*TP + h1[p]] = 1'b1;
            if (h1[p] != h2[p]) v[p*TP + h2[p]] = 1'b1;
        end
        return v;
    endfunction

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            n_cmp++;
            if (ack !== e_ack) begin
                n_bad++; $display("FAIL R10 [%s] ack got %0b exp %0b", cur_req, ack, e_ack);
            end
            n_cmp++;
            if (rd_valid !== e_rdv || rd_data !== 8'(e_rdd)) begin
                n_bad++; $display("FAIL R7 [%s] read got %0b/%0d exp %0b/%0d",
                                  cur_req, rd_valid, rd_data, e_rdv, e_rdd);
            end
            n_cmp++;
            if (busy !== (m_busy > 0)) begin
                n_bad++; $display("FAIL R8 [%s] busy got %0b exp %0b", cur_req, busy, m_busy > 0);
            end
            n_cmp++;
            if (tap_en !== exp_taps()) begin
                n_bad++; $display("FAIL R11 [%s] taps got %h exp %h", cur_req, tap_en, exp_taps());
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(input string req, input int got, input int exp, input string what);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got %0d exp %0d", req, what, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
        l_ack = ack; l_rdv = rd_valid; l_rdd = rd_data;
    endtask

    task automatic start_c();
        @(negedge clk); bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic stop_c();
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic wr_pot(input logic [7:0] ins, input logic [7:0] d, input string req);
        start_c(); send(8'hAE); chk(req, l_ack, 1, "addr ack");
        tick(1); send(ins); chk(req, l_ack, 1, "instr ack");
        tick(1); send(d); chk(req, l_ack, 1, "data ack");
        tick(2); stop_c(); tick(2);
    endtask

    task automatic rd_pot(input int idx, output int val);
        start_c(); send(8'hAE); tick(1); send(8'(idx)); tick(1);
        start_c(); send(8'hAF);
        val = l_rdv ? int'(l_rdd) : -1;
        tick(1); send(8'h12); chk("R7", l_ack, 0, "byte after read answer");
        stop_c(); tick(2);
    endtask

    task automatic pwr_cycle();
        pwr_good = 1'b0; tick(3); pwr_good = 1'b1; tick(PU + 4);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        int v;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        cmp_on = 1'b1;
        cur_req = "R1";
        chk("R1", ack, 0, "ack after reset");
        chk("R1", busy, 0, "busy after reset");
        chk("R1", tap_en[0], 1, "pot0 tap0 after reset");
        chk("R1", $countones(tap_en), NP, "one tap per pot after reset");
        start_c(); send(8'hAE);
        chk("R1", l_ack, 0, "addr before supply good");
        stop_c();
        pwr_good = 1'b1; tick(PU + 4);
        chk("R1", tap_en[TP + NI], 1, "pot1 recalled to NV_INIT");
        chk("R1", $countones(tap_en[TP +: TP]), 1, "pot1 single tap");

        cur_req = "R2";
        pwr_good = 1'b0; tick(2); pwr_good = 1'b1; tick(8);
        pwr_good = 1'b0; tick(1); pwr_good = 1'b1; tick(PU - 5);
        start_c(); send(8'hAE);
        chk("R2", l_ack, 0, "addr during requalification");
        stop_c(); tick(PU + 2);

        cur_req = "R3";
        start_c(); send(8'hA0); chk("R3", l_ack, 0, "wrong device id");
        tick(1); send(8'h01); chk("R3", l_ack, 0, "instr after bad addr");
        stop_c();
        start_c(); send(8'hAF); chk("R3", l_ack, 0, "read flag as first byte");
        stop_c(); tick(2);

        cur_req = "R5";
        wr_pot(8'h01, 8'd20, "R5");
        cur_req = "R7";
        rd_pot(1, v); chk("R7", v, 20, "read pot1");

        cur_req = "R6";
        start_c(); send(8'hAE); tick(1); send(8'h82); tick(1); send(8'd42);
        chk("R6", l_ack, 1, "persistent data ack");
        chk("R8", busy, 1, "busy after persistent write");
        tick(2); stop_c();
        cur_req = "R8";
        start_c(); send(8'hAE); chk("R8", l_ack, 0, "addr while busy");
        stop_c(); tick(NB);
        chk("R8", busy, 0, "busy released");

        cur_req = "R11";
        start_c(); send(8'hAE); tick(1); send(8'h00); tick(1); send(8'd9);
        @(negedge clk);
        chk("R11", $countones(tap_en[0 +: TP]), 2, "overlap count");
        chk("R11", tap_en[NI] & tap_en[9], 1, "old and new both on");
        @(negedge clk);
        chk("R11", $countones(tap_en[0 +: TP]), 1, "single after overlap");
        chk("R11", tap_en[9], 1, "new tap on");
        stop_c(); tick(2);

        cur_req = "R12";
        wr_pot(8'h00, 8'hFF, "R12");
        rd_pot(0, v); chk("R12", v, 63, "upper data bits dropped");

        cur_req = "R4";
        start_c(); send(8'hAE); tick(1); send(8'h03); chk("R4", l_ack, 0, "index 3");
        tick(1); send(8'd7); chk("R4", l_ack, 0, "data after index 3");
        stop_c(); tick(2);

        cur_req = "R9";
        start_c(); send(8'hAE); tick(1); send(8'h01); stop_c(); tick(2);
        send(8'd33); chk("R13", l_ack, 0, "byte after stop without start");
        tick(2);
        rd_pot(1, v); chk("R9", v, 20, "pot1 unchanged after abort");

        cur_req = "R5";
        pwr_cycle();
        rd_pot(0, v); chk("R5", v, NI, "volatile pot0 reverts");
        rd_pot(1, v); chk("R5", v, NI, "volatile pot1 reverts");
        rd_pot(2, v); chk("R6", v, 42, "persistent pot2 kept");
        tick(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog [%s] got timeout exp completion", cur_req);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule